// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects hardware events into a small set of sticky status bits and drives one level-sensitive interrupt line. Each status bit has a mask bit. The interrupt is raised while any status bit is set and its mask bit is clear. Software reaches the block through a plain 32-bit register port with an address, a write enable, write data and read data. The port has no handshake, and only aligned word addresses are decoded.

Software cannot write the mask directly. It changes the mask through two write-only alias registers. Writing ones to the unmask alias clears the matching mask bits. Writing ones to the mask alias sets them. Both aliases read back as zero. Status bits are cleared by writing one to them. A hardware event arriving in the same cycle as a clear takes precedence, so no event is lost. The number of sources is a parameter and defaults to one.

Register map (byte offsets, word aligned): status at 0x0, mask view at 0x4, unmask alias at 0x8, mask alias at 0xC.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After synchronous reset every status bit is 0, every mask bit is 1, `irq` is 0 and `rd_data` is 0.
- R2: `irq` is registered. In each cycle it equals the OR over all sources of (status AND NOT mask), taken from the state held one clock earlier.
- R3: A write to offset 0x0 clears each status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value.
- R4: A 1 on `hw_event[i]` sets status bit i at the next edge, even when a write-one-to-clear of that bit happens in the same cycle.
- R5: The mask is read at offset 0x4, and writes to 0x4 leave the mask unchanged.
- R6: A write to offset 0x8 clears each mask bit whose `wr_data` bit is 1 and leaves the others unchanged.
- R7: A write to offset 0xC sets each mask bit whose `wr_data` bit is 1 and leaves the others unchanged.
- R8: Offsets 0x8 and 0xC store nothing of their own and read as zero.
- R9: An address whose two low bits are not 00, or that is not one of the four offsets, changes no state on a write and reads as zero.
- R10: `rd_data` is registered. After each clock edge it holds the register selected by `addr` at that edge, taken before that edge's updates, with status and mask placed from bit 0 upward and all higher bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | DATA_W | Write data, little-endian word |
| rd_data | output | DATA_W | Registered read data |
| hw_event | input | NUM_SRC | Event pulses, one per source |
| irq | output | 1 | Registered level interrupt |

## Verification
Directed sequences test each mechanism on its own. Unmasking an already pending status bit shows the one-cycle delay of `irq`. An event combined with a same-cycle clear shows whether the event takes precedence. Writes to the mask view, to the aliases and to unaligned or unmapped addresses show whether any stray path changes state. The aliases and unmapped addresses are then read back to confirm they return zero. A seeded random stream then mixes writes, reads and events over valid, misaligned and out-of-range addresses. In this stream, every cycle's `irq` and `rd_data` are compared with a bench model, which catches ordering errors between status, mask and the read register.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int unsigned OFS_STATUS  = 'h0;
  localparam int unsigned OFS_MASK    = 'h4;
  localparam int unsigned OFS_UNMASK  = 'h8;
  localparam int unsigned OFS_SETMASK = 'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_UNMASK,
    SEL_SETMASK
  } reg_sel_e;
endpackage

// File: rtl/imc_decode.sv
module imc_decode
  import imc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output reg_sel_e          sel,
  output logic              clr_status,
  output logic              clr_mask,
  output logic              set_mask
);
  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (addr == ADDR_W'(OFS_STATUS))       sel = SEL_STATUS;
      else if (addr == ADDR_W'(OFS_MASK))    sel = SEL_MASK;
      else if (addr == ADDR_W'(OFS_UNMASK))  sel = SEL_UNMASK;
      else if (addr == ADDR_W'(OFS_SETMASK)) sel = SEL_SETMASK;
    end
  end

  assign clr_status = wr_en && (sel == SEL_STATUS);
  assign clr_mask   = wr_en && (sel == SEL_UNMASK);
  assign set_mask   = wr_en && (sel == SEL_SETMASK);
endmodule

// File: rtl/imc_state.sv
module imc_state #(
  parameter int unsigned NUM_SRC = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic               clr_status,
  input  logic               clr_mask,
  input  logic               set_mask,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] mask_q
);
  logic [NUM_SRC-1:0] clr_bits;
  assign clr_bits = clr_status ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr_bits) | evt;
      if (set_mask)      mask_q <= mask_q | wdata;
      else if (clr_mask) mask_q <= mask_q & ~wdata;
    end
  end
endmodule

// File: rtl/imc_irq.sv
module imc_irq #(
  parameter int unsigned NUM_SRC = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status_q,
  input  logic [NUM_SRC-1:0] mask_q,
  output logic               irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_q & ~mask_q);
  end
endmodule

// File: rtl/imc_rdport.sv
module imc_rdport
  import imc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 1,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] status_q,
  input  logic [NUM_SRC-1:0] mask_q,
  output logic [DATA_W-1:0]  rd_q
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    case (sel)
      SEL_STATUS: rd_next = DATA_W'(status_q);
      SEL_MASK:   rd_next = DATA_W'(mask_q);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import imc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 1,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] hw_event,
  output logic               irq
);
  reg_sel_e           sel;
  logic               clr_status, clr_mask, set_mask;
  logic [NUM_SRC-1:0] wdata_src;
  logic [NUM_SRC-1:0] status_q, mask_q;

  assign wdata_src = wr_data[NUM_SRC-1:0];

  generate
    if (NUM_SRC < DATA_W) begin : g_hi
      logic hi_unused;
      assign hi_unused = ^wr_data[DATA_W-1:NUM_SRC];
    end
  endgenerate

  imc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .sel(sel),
    .clr_status(clr_status), .clr_mask(clr_mask), .set_mask(set_mask)
  );

  imc_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk(clk), .rst(rst), .evt(hw_event), .wdata(wdata_src),
    .clr_status(clr_status), .clr_mask(clr_mask), .set_mask(set_mask),
    .status_q(status_q), .mask_q(mask_q)
  );

  imc_irq #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk(clk), .rst(rst), .status_q(status_q), .mask_q(mask_q), .irq_q(irq)
  );

  imc_rdport #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .status_q(status_q), .mask_q(mask_q),
    .rd_q(rd_data)
  );
endmodule

// File: rtl/imc_checker.sv
module imc_checker
  import imc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 1,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wr_data,
  input logic [NUM_SRC-1:0] hw_event,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq
);
  logic [NUM_SRC-1:0] wd;
  logic w_stat, w_mask, w_unm, w_set, w_bad;
  assign wd     = wr_data[NUM_SRC-1:0];
  assign w_stat = wr_en && addr == ADDR_W'(OFS_STATUS);
  assign w_mask = wr_en && addr == ADDR_W'(OFS_MASK);
  assign w_unm  = wr_en && addr == ADDR_W'(OFS_UNMASK);
  assign w_set  = wr_en && addr == ADDR_W'(OFS_SETMASK);
  assign w_bad  = wr_en && (addr[1:0] != 2'b00 || addr > ADDR_W'(OFS_SETMASK));

  AST_IRQ_FOLLOWS : assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (irq == $past(|(status_q & ~mask_q)))); // R2
  AST_W1C_CLEARS : assert property (@(posedge clk) disable iff (rst) (w_stat && hw_event == '0) |=> ((status_q & $past(wd)) == '0)); // R3
  AST_EVENT_SETS : assert property (@(posedge clk) disable iff (rst) (hw_event != '0) |=> ((status_q & $past(hw_event)) == $past(hw_event))); // R4
  AST_MASK_RO : assert property (@(posedge clk) disable iff (rst) w_mask |=> $stable(mask_q)); // R5
  AST_UNMASK_CLEARS : assert property (@(posedge clk) disable iff (rst) w_unm |=> ((mask_q & $past(wd)) == '0)); // R6
  AST_SETMASK_SETS : assert property (@(posedge clk) disable iff (rst) w_set |=> ((mask_q & $past(wd)) == $past(wd))); // R7
  AST_BAD_ADDR_INERT : assert property (@(posedge clk) disable iff (rst) (w_bad && hw_event == '0) |=> ($stable(status_q) && $stable(mask_q))); // R9
endmodule

bind irq_mask_ctrl imc_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .hw_event(hw_event), .status_q(status_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;
  localparam int unsigned NSRC = 1;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NSRC-1:0] hw_event = '0;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [NSRC-1:0] m_status, m_mask;

  always #5 clk = ~clk;

  irq_mask_ctrl #(.NUM_SRC(NSRC), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .hw_event(hw_event), .irq(irq)
  );

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a, logic [NSRC-1:0] st, logic [NSRC-1:0] mk);
    if (a == 8'h00) return DW'(st);
    if (a == 8'h04) return DW'(mk);
    return '0;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One access cycle: drive at negedge, model the edge, check after it.
  task automatic access(logic [AW-1:0] a, logic we, logic [DW-1:0] d, logic [NSRC-1:0] ev, string tag);
    logic [DW-1:0]  e_rd;
    logic           e_irq;
    logic [NSRC-1:0] wd;
    addr = a; wr_en = we; wr_data = d; hw_event = ev;
    e_rd  = exp_read(a, m_status, m_mask);
    e_irq = |(m_status & ~m_mask);
    wd    = d[NSRC-1:0];
    @(posedge clk);
    if (we && a == 8'h00) m_status = m_status & ~wd;
    m_status = m_status | ev;
    if (we && a == 8'h08) m_mask = m_mask & ~wd;
    if (we && a == 8'h0C) m_mask = m_mask | wd;
    #1;
    check({tag, " R2 irq"}, DW'(irq), DW'(e_irq));
    check({tag, " R10 rd"}, rd_data, e_rd);
    @(negedge clk);
    wr_en = 1'b0; hw_event = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    m_status = '0; m_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    check("R1 irq", DW'(irq), '0);
    check("R1 rd", rd_data, '0);
    access(8'h04, 0, '0, '0, "R1 mask reads one");
    access(8'h00, 0, '0, '0, "R1 status reads zero");
    // R4: event sets status while masked, irq stays low
    access(8'h00, 0, '0, 1'b1, "R4 event");
    access(8'h00, 0, '0, '0, "R4 status set");
    // R6: unmask, irq rises one cycle later
    access(8'h08, 1, 32'h1, '0, "R6 unmask");
    access(8'h04, 0, '0, '0, "R6 mask cleared");
    access(8'h04, 0, '0, '0, "R2 irq high");
    // R3: write zero keeps, write one clears
    access(8'h00, 1, 32'h0, '0, "R3 write zero");
    access(8'h00, 0, '0, '0, "R3 still set");
    access(8'h00, 1, 32'h1, '0, "R3 write one");
    access(8'h00, 0, '0, '0, "R3 cleared");
    // R4: event beats same-cycle clear
    access(8'h00, 0, '0, 1'b1, "R4 set again");
    access(8'h00, 1, 32'h1, 1'b1, "R4 event vs clear");
    access(8'h00, 0, '0, '0, "R4 event wins");
    // R5: mask view is read-only
    access(8'h04, 1, 32'hFFFF_FFFF, '0, "R5 write mask view");
    access(8'h04, 0, '0, '0, "R5 mask unchanged");
    // R7: set mask, irq drops
    access(8'h0C, 1, 32'h1, '0, "R7 setmask");
    access(8'h04, 0, '0, '0, "R7 mask set");
    // R8: aliases read zero
    access(8'h08, 0, '0, '0, "R8 unmask reads zero");
    access(8'h0C, 0, '0, '0, "R8 setmask reads zero");
    // R9: unaligned / unmapped writes ignored, read zero
    access(8'h09, 1, 32'h1, '0, "R9 unaligned unmask");
    access(8'h01, 1, 32'h1, '0, "R9 unaligned status");
    access(8'h10, 1, 32'h1, '0, "R9 unmapped");
    access(8'h04, 0, '0, '0, "R9 mask intact");
    access(8'h00, 0, '0, '0, "R9 status intact");
    // Random mix
    begin
      int seed_dummy;
      logic [AW-1:0] pool [8];
      seed_dummy = $urandom(32'h1F2E_3D4C);
      pool[0] = 8'h00; pool[1] = 8'h04; pool[2] = 8'h08; pool[3] = 8'h0C;
      pool[4] = 8'h01; pool[5] = 8'h06; pool[6] = 8'h10; pool[7] = 8'h40;
      for (int i = 0; i < 400; i++) begin
        access(pool[$urandom_range(0, 7)], 1'($urandom_range(0, 1)),
               $urandom(), NSRC'($urandom_range(0, 3) == 0), "RND");
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule